// File: doc/BRIEF.md
# UART Banked Register Access Decoder

This block is the register front end of a 16550-compatible serial port that also carries an enhanced register set. Eight bus offsets are shared between more registers than they can address, so the value held in the line control register picks which physical register each offset reaches. The block decodes that value into one of three access banks: operational, configuration A and configuration B. It then steers every bus write and read to the register that the active bank exposes.

The block holds the line control, divisor low and high, interrupt enable, FIFO control, enhanced feature, modem control, transmit control, trigger level and scratch registers. A feature-enable bit in the enhanced feature register guards certain bits and registers. Status bytes, the interrupt identification byte and received data come from outside the block. A write to the data offset in operational mode becomes a one-cycle transmit strobe. Read data is registered.

Top module: `uart_bank_decoder`

## Requirements
- R1: `cfg_mode` reports the active bank as 0 (operational) when LCR bit 7 is 0, 2 (configuration B) when LCR equals exactly 0xBF, and 1 (configuration A) for every other LCR value with bit 7 set.
- R2: A synchronous active-high reset clears every held register, `bus_rdata`, `tx_strobe` and `rx_pop` to 0, which leaves the block in bank 0.
- R3: Offset 3 writes and reads LCR in every bank. A written value selects the bank for the access in the next cycle.
- R4: In banks 1 and 2, offsets 0 and 1 reach the divisor low and high bytes. In bank 0, offset 1 reaches IER. An offset 0 write in bank 0 pulses `tx_strobe` for one cycle with `tx_data` equal to the written byte. An offset 0 read in bank 0 returns `rx_data` and pulses `rx_pop`.
- R5: In bank 2, offset 2 writes and reads the enhanced feature register (EFR). In banks 0 and 1, an offset 2 write goes to FCR and an offset 2 read returns `iir_in`.
- R6: In banks 0 and 1, offset 4 reaches MCR. In bank 2, offset 4 reads 0 and writes to it are ignored.
- R7: MCR bits 7 and 6 take a written value only while EFR bit 4 is 1. Otherwise they keep their old value, and bits 5..0 are still written.
- R8: IER bit 4 takes a written value only while EFR bit 4 is 1. The other IER bits are always written.
- R9: While EFR bit 4 and MCR bit 6 are both 1, offsets 6 and 7 read and write TCR and TLR. Otherwise offset 6 reads `msr_in` and ignores writes, and offset 7 reads and writes the scratch register.
- R10: Offset 5 reads `lsr_in` in every bank, and writes to it change no register.
- R11: Read data appears on `bus_rdata` in the cycle after `bus_rd` and holds while `bus_rd` is low. A read and a write in the same cycle return the register's contents from before the write, decoded with the LCR value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write enable |
| bus_rd | input | 1 | Read enable |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| iir_in | input | 8 | Interrupt identification byte |
| lsr_in | input | 8 | Line status byte |
| msr_in | input | 8 | Modem status byte |
| rx_data | input | 8 | Head of receive buffer |
| rx_pop | output | 1 | Pulse: receive byte consumed |
| tx_strobe | output | 1 | Pulse: transmit byte written |
| tx_data | output | 8 | Transmit byte |
| cfg_mode | output | 2 | Active bank: 0 op, 1 config A, 2 config B |
| lcr_q | output | 8 | Line control register |
| dll_q | output | 8 | Divisor low byte |
| dlh_q | output | 8 | Divisor high byte |
| ier_q | output | 8 | Interrupt enable register |
| fcr_q | output | 8 | FIFO control register |
| efr_q | output | 8 | Enhanced feature register |
| mcr_q | output | 8 | Modem control register |
| tcr_q | output | 8 | Transmit control register |
| tlr_q | output | 8 | Trigger level register |

## Verification
A read and a write can fall in the same cycle, and when the write targets LCR it also changes the bank. The bench raises `bus_rd` and `bus_wr` together on the LCR offset while it moves from bank 1 to bank 2. It checks that the returned byte is the old LCR value and that `cfg_mode` shows the new bank one cycle later. It then does the same on offset 2 in bank 2 and checks that the old EFR is read back while the new EFR lands on `efr_q`. All 256 LCR values are swept to check the bank decode, and the lock behaviour is checked with the feature enable both cleared and set.

// File: rtl/uart_bank_pkg.sv
package uart_bank_pkg;

  typedef enum logic [1:0] {
    MODE_OP    = 2'd0,
    MODE_CFG_A = 2'd1,
    MODE_CFG_B = 2'd2
  } acc_mode_e;

  localparam int OFS_DATA = 0;
  localparam int OFS_IER  = 1;
  localparam int OFS_FIFO = 2;
  localparam int OFS_LCR  = 3;
  localparam int OFS_MCR  = 4;
  localparam int OFS_LSR  = 5;
  localparam int OFS_MSR  = 6;
  localparam int OFS_SPR  = 7;

endpackage

// File: rtl/bank_mode_decode.sv
module bank_mode_decode
  import uart_bank_pkg::*;
#(
  parameter int          DW          = 8,
  parameter logic [DW-1:0] CONF_B_CODE = 8'hBF
) (
  input  logic [DW-1:0] lcr,
  output acc_mode_e     mode
);

  always_comb begin
    if (!lcr[DW-1])             mode = MODE_OP;
    else if (lcr == CONF_B_CODE) mode = MODE_CFG_B;
    else                        mode = MODE_CFG_A;
  end

endmodule

// File: rtl/bank_write_path.sv
module bank_write_path
  import uart_bank_pkg::*;
#(
  parameter int            DW            = 8,
  parameter int            AW            = 3,
  parameter int            ENH_BIT       = 4,
  parameter logic [DW-1:0] IER_LOCK_MASK = 8'h10,
  parameter logic [DW-1:0] MCR_LOCK_MASK = 8'hC0,
  parameter logic [DW-1:0] CONF_B_CODE   = 8'hBF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  input  acc_mode_e     mode,
  input  logic          tcr_sel,
  output logic [DW-1:0] lcr_q,
  output logic [DW-1:0] dll_q,
  output logic [DW-1:0] dlh_q,
  output logic [DW-1:0] ier_q,
  output logic [DW-1:0] fcr_q,
  output logic [DW-1:0] efr_q,
  output logic [DW-1:0] mcr_q,
  output logic [DW-1:0] tcr_q,
  output logic [DW-1:0] tlr_q,
  output logic [DW-1:0] spr_q,
  output logic          tx_strobe,
  output logic [DW-1:0] tx_data
);

  logic          enh;
  logic [DW-1:0] ier_next;
  logic [DW-1:0] mcr_next;

  assign enh = efr_q[ENH_BIT];

  // merge written value with held value on locked bits
  assign ier_next = (wdata & ~IER_LOCK_MASK) | ((enh ? wdata : ier_q) & IER_LOCK_MASK);
  assign mcr_next = (wdata & ~MCR_LOCK_MASK) | ((enh ? wdata : mcr_q) & MCR_LOCK_MASK);

  always_ff @(posedge clk) begin
    if (rst) begin
      lcr_q     <= '0;
      dll_q     <= '0;
      dlh_q     <= '0;
      ier_q     <= '0;
      fcr_q     <= '0;
      efr_q     <= '0;
      mcr_q     <= '0;
      tcr_q     <= '0;
      tlr_q     <= '0;
      spr_q     <= '0;
      tx_strobe <= 1'b0;
      tx_data   <= '0;
    end else begin
      tx_strobe <= 1'b0;
      if (wr_en) begin
        case (addr)
          AW'(OFS_DATA): begin
            if (mode == MODE_OP) begin
              tx_strobe <= 1'b1;
              tx_data   <= wdata;
            end else begin
              dll_q <= wdata;
            end
          end
          AW'(OFS_IER): begin
            if (mode == MODE_OP) ier_q <= ier_next;
            else                 dlh_q <= wdata;
          end
          AW'(OFS_FIFO): begin
            if (mode == MODE_CFG_B) efr_q <= wdata;
            else                    fcr_q <= wdata;
          end
          AW'(OFS_LCR): lcr_q <= wdata;
          AW'(OFS_MCR): begin
            if (mode != MODE_CFG_B) mcr_q <= mcr_next;
          end
          AW'(OFS_MSR): begin
            if (tcr_sel) tcr_q <= wdata;
          end
          AW'(OFS_SPR): begin
            if (tcr_sel) tlr_q <= wdata;
            else         spr_q <= wdata;
          end
          default: ;
        endcase
      end
    end
  end

  AST_IER_SLEEP_LOCK: assert property (@(posedge clk) disable iff (rst)
    !enh |=> ((ier_q & IER_LOCK_MASK) == ($past(ier_q) & IER_LOCK_MASK))); // R8

  AST_MCR_HIGH_LOCK: assert property (@(posedge clk) disable iff (rst)
    !enh |=> ((mcr_q & MCR_LOCK_MASK) == ($past(mcr_q) & MCR_LOCK_MASK))); // R7

  AST_EFR_ONLY_IN_B: assert property (@(posedge clk) disable iff (rst)
    (mode != MODE_CFG_B) |=> $stable(efr_q)); // R5

  AST_TX_ONLY_IN_OP: assert property (@(posedge clk) disable iff (rst)
    (mode != MODE_OP) |=> !tx_strobe); // R4

  AST_MODE_B_CODE: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_CFG_B) |-> (lcr_q == CONF_B_CODE)); // R1

  AST_LCR_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == AW'(OFS_LCR)) |=> (lcr_q == $past(wdata))); // R3

endmodule

// File: rtl/bank_read_mux.sv
module bank_read_mux
  import uart_bank_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          rd_en,
  input  acc_mode_e     mode,
  input  logic          tcr_sel,
  input  logic [DW-1:0] lcr_q,
  input  logic [DW-1:0] dll_q,
  input  logic [DW-1:0] dlh_q,
  input  logic [DW-1:0] ier_q,
  input  logic [DW-1:0] efr_q,
  input  logic [DW-1:0] mcr_q,
  input  logic [DW-1:0] tcr_q,
  input  logic [DW-1:0] tlr_q,
  input  logic [DW-1:0] spr_q,
  input  logic [DW-1:0] iir_in,
  input  logic [DW-1:0] lsr_in,
  input  logic [DW-1:0] msr_in,
  input  logic [DW-1:0] rx_data,
  output logic [DW-1:0] rdata,
  output logic          rx_pop
);

  logic [DW-1:0] sel_data;
  logic          pop_now;

  always_comb begin
    sel_data = '0;
    pop_now  = 1'b0;
    case (addr)
      AW'(OFS_DATA): begin
        if (mode == MODE_OP) begin
          sel_data = rx_data;
          pop_now  = 1'b1;
        end else begin
          sel_data = dll_q;
        end
      end
      AW'(OFS_IER):  sel_data = (mode == MODE_OP) ? ier_q : dlh_q;
      AW'(OFS_FIFO): sel_data = (mode == MODE_CFG_B) ? efr_q : iir_in;
      AW'(OFS_LCR):  sel_data = lcr_q;
      AW'(OFS_MCR):  sel_data = (mode == MODE_CFG_B) ? '0 : mcr_q;
      AW'(OFS_LSR):  sel_data = lsr_in;
      AW'(OFS_MSR):  sel_data = tcr_sel ? tcr_q : msr_in;
      AW'(OFS_SPR):  sel_data = tcr_sel ? tlr_q : spr_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rx_pop <= 1'b0;
    end else begin
      rx_pop <= rd_en & pop_now;
      if (rd_en) rdata <= sel_data;
    end
  end

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata)); // R11

  AST_RX_POP_SOURCE: assert property (@(posedge clk) disable iff (rst)
    rx_pop |-> $past(rd_en && addr == AW'(OFS_DATA) && mode == MODE_OP)); // R4

  AST_B_HIDES_MCR: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == AW'(OFS_MCR) && mode == MODE_CFG_B) |=> (rdata == '0)); // R6

endmodule

// File: rtl/uart_bank_decoder.sv
module uart_bank_decoder
  import uart_bank_pkg::*;
#(
  parameter int            DW            = 8,
  parameter int            AW            = 3,
  parameter logic [DW-1:0] CONF_B_CODE   = 8'hBF,
  parameter int            ENH_BIT       = 4,
  parameter int            TCR_EN_BIT    = 6,
  parameter logic [DW-1:0] IER_LOCK_MASK = 8'h10,
  parameter logic [DW-1:0] MCR_LOCK_MASK = 8'hC0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [DW-1:0] iir_in,
  input  logic [DW-1:0] lsr_in,
  input  logic [DW-1:0] msr_in,
  input  logic [DW-1:0] rx_data,
  output logic          rx_pop,
  output logic          tx_strobe,
  output logic [DW-1:0] tx_data,
  output logic [1:0]    cfg_mode,
  output logic [DW-1:0] lcr_q,
  output logic [DW-1:0] dll_q,
  output logic [DW-1:0] dlh_q,
  output logic [DW-1:0] ier_q,
  output logic [DW-1:0] fcr_q,
  output logic [DW-1:0] efr_q,
  output logic [DW-1:0] mcr_q,
  output logic [DW-1:0] tcr_q,
  output logic [DW-1:0] tlr_q
);

  acc_mode_e     mode;
  logic          tcr_sel;
  logic [DW-1:0] spr_q;

  assign tcr_sel  = efr_q[ENH_BIT] & mcr_q[TCR_EN_BIT];
  assign cfg_mode = mode;

  bank_mode_decode #(
    .DW(DW), .CONF_B_CODE(CONF_B_CODE)
  ) u_decode (
    .lcr  (lcr_q),
    .mode (mode)
  );

  bank_write_path #(
    .DW(DW), .AW(AW), .ENH_BIT(ENH_BIT),
    .IER_LOCK_MASK(IER_LOCK_MASK), .MCR_LOCK_MASK(MCR_LOCK_MASK),
    .CONF_B_CODE(CONF_B_CODE)
  ) u_write (
    .clk       (clk),
    .rst       (rst),
    .addr      (bus_addr),
    .wr_en     (bus_wr),
    .wdata     (bus_wdata),
    .mode      (mode),
    .tcr_sel   (tcr_sel),
    .lcr_q     (lcr_q),
    .dll_q     (dll_q),
    .dlh_q     (dlh_q),
    .ier_q     (ier_q),
    .fcr_q     (fcr_q),
    .efr_q     (efr_q),
    .mcr_q     (mcr_q),
    .tcr_q     (tcr_q),
    .tlr_q     (tlr_q),
    .spr_q     (spr_q),
    .tx_strobe (tx_strobe),
    .tx_data   (tx_data)
  );

  bank_read_mux #(
    .DW(DW), .AW(AW)
  ) u_read (
    .clk     (clk),
    .rst     (rst),
    .addr    (bus_addr),
    .rd_en   (bus_rd),
    .mode    (mode),
    .tcr_sel (tcr_sel),
    .lcr_q   (lcr_q),
    .dll_q   (dll_q),
    .dlh_q   (dlh_q),
    .ier_q   (ier_q),
    .efr_q   (efr_q),
    .mcr_q   (mcr_q),
    .tcr_q   (tcr_q),
    .tlr_q   (tlr_q),
    .spr_q   (spr_q),
    .iir_in  (iir_in),
    .lsr_in  (lsr_in),
    .msr_in  (msr_in),
    .rx_data (rx_data),
    .rdata   (bus_rdata),
    .rx_pop  (rx_pop)
  );

endmodule

// File: tb/test_uart_bank_decoder.sv
module test_uart_bank_decoder;

  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] bus_addr;
  logic       bus_wr, bus_rd;
  logic [7:0] bus_wdata, bus_rdata;
  logic [7:0] iir_in, lsr_in, msr_in, rx_data;
  logic       rx_pop, tx_strobe;
  logic [7:0] tx_data;
  logic [1:0] cfg_mode;
  logic [7:0] lcr_q, dll_q, dlh_q, ier_q, fcr_q, efr_q, mcr_q, tcr_q, tlr_q;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  uart_bank_decoder i_uart_bank_decoder (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .iir_in(iir_in), .lsr_in(lsr_in),
    .msr_in(msr_in), .rx_data(rx_data), .rx_pop(rx_pop), .tx_strobe(tx_strobe),
    .tx_data(tx_data), .cfg_mode(cfg_mode), .lcr_q(lcr_q), .dll_q(dll_q),
    .dlh_q(dlh_q), .ier_q(ier_q), .fcr_q(fcr_q), .efr_q(efr_q), .mcr_q(mcr_q),
    .tcr_q(tcr_q), .tlr_q(tlr_q)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%02h exp=%02h", req, got, exp);
    end
  endtask

  // drive at a falling edge, release at the next one; results are visible then
  task automatic acc(input logic [2:0] a, input logic [7:0] d, input bit w, input bit r);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = w;
    bus_rd    = r;
    @(negedge clk);
    bus_wr = 1'b0;
    bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    acc(a, d, 1'b1, 1'b0);
  endtask

  task automatic rd(input logic [2:0] a);
    acc(a, 8'h00, 1'b0, 1'b1);
  endtask

  function automatic logic [7:0] exp_mode(input logic [7:0] v);
    if (v == 8'hBF) return 8'd2;
    if (v[7])       return 8'd1;
    return 8'd0;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0;
    iir_in = 8'hC1; lsr_in = 8'h60; msr_in = 8'h5B; rx_data = 8'h3C;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R2 reset state
    chk("R2 mode", {6'd0, cfg_mode}, 8'd0);
    chk("R2 lcr", lcr_q, 8'h00);
    chk("R2 rdata", bus_rdata, 8'h00);
    chk("R2 efr", efr_q, 8'h00);
    chk("R2 mcr", mcr_q, 8'h00);

    // R4 operational data offset
    wr(3'd0, 8'h5A);
    chk("R4 tx_strobe", {7'd0, tx_strobe}, 8'd1);
    chk("R4 tx_data", tx_data, 8'h5A);
    chk("R4 dll untouched", dll_q, 8'h00);
    @(negedge clk);
    chk("R4 tx_strobe one cycle", {7'd0, tx_strobe}, 8'd0);
    rd(3'd0);
    chk("R4 rx read", bus_rdata, 8'h3C);
    chk("R4 rx_pop", {7'd0, rx_pop}, 8'd1);
    // R8 sleep bit locked while enable is 0
    wr(3'd1, 8'hFF);
    chk("R8 ier locked", ier_q, 8'hEF);
    rd(3'd1);
    chk("R4 ier read", bus_rdata, 8'hEF);

    // R1 R3 sweep every LCR value
    for (int v = 0; v < 256; v++) begin
      wr(3'd3, 8'(v));
      chk("R1 mode decode", {6'd0, cfg_mode}, exp_mode(8'(v)));
      rd(3'd3);
      chk("R3 lcr readback", bus_rdata, 8'(v));
    end

    // configuration A
    wr(3'd3, 8'h80);
    wr(3'd0, 8'h12);
    wr(3'd1, 8'h34);
    chk("R4 dll A", dll_q, 8'h12);
    chk("R4 dlh A", dlh_q, 8'h34);
    chk("R4 ier kept", ier_q, 8'hEF);
    rd(3'd1);
    chk("R4 dlh read", bus_rdata, 8'h34);
    wr(3'd2, 8'h07);
    chk("R5 fcr", fcr_q, 8'h07);
    chk("R5 efr untouched", efr_q, 8'h00);
    rd(3'd2);
    chk("R5 iir read", bus_rdata, 8'hC1);
    wr(3'd4, 8'hFF);
    chk("R7 mcr locked", mcr_q, 8'h3F);
    rd(3'd4);
    chk("R6 mcr read A", bus_rdata, 8'h3F);

    // configuration B
    wr(3'd3, 8'hBF);
    wr(3'd2, 8'h10);
    chk("R5 efr write", efr_q, 8'h10);
    chk("R5 fcr kept", fcr_q, 8'h07);
    rd(3'd2);
    chk("R5 efr read", bus_rdata, 8'h10);
    wr(3'd0, 8'h56);
    rd(3'd0);
    chk("R4 dll B", bus_rdata, 8'h56);
    chk("R4 no rx_pop in B", {7'd0, rx_pop}, 8'd0);
    rd(3'd4);
    chk("R6 offset4 reads 0 in B", bus_rdata, 8'h00);
    wr(3'd4, 8'hAA);
    chk("R6 mcr write ignored in B", mcr_q, 8'h3F);

    // R8 sleep bit writable with enable set
    wr(3'd3, 8'h03);
    wr(3'd1, 8'hFF);
    chk("R8 ier unlocked", ier_q, 8'hFF);

    // R7 R9 extended access
    wr(3'd3, 8'h80);
    wr(3'd4, 8'hC0);
    chk("R7 mcr unlocked", mcr_q, 8'hC0);
    wr(3'd6, 8'h9A);
    wr(3'd7, 8'h44);
    chk("R9 tcr", tcr_q, 8'h9A);
    chk("R9 tlr", tlr_q, 8'h44);
    rd(3'd6);
    chk("R9 tcr read", bus_rdata, 8'h9A);
    rd(3'd7);
    chk("R9 tlr read", bus_rdata, 8'h44);
    wr(3'd4, 8'h00);
    wr(3'd7, 8'h77);
    wr(3'd6, 8'h11);
    chk("R9 tlr kept", tlr_q, 8'h44);
    chk("R9 tcr kept", tcr_q, 8'h9A);
    rd(3'd7);
    chk("R9 spr read", bus_rdata, 8'h77);
    rd(3'd6);
    chk("R9 msr read", bus_rdata, 8'h5B);

    // R10 status offset
    rd(3'd5);
    chk("R10 lsr read", bus_rdata, 8'h60);
    wr(3'd5, 8'hFF);
    chk("R10 lcr kept", lcr_q, 8'h80);
    chk("R10 mcr kept", mcr_q, 8'h00);
    rd(3'd7);
    chk("R10 spr kept", bus_rdata, 8'h77);

    // R11 same-cycle read and write
    acc(3'd3, 8'hBF, 1'b1, 1'b1);
    chk("R11 old lcr read", bus_rdata, 8'h80);
    chk("R11 new mode", {6'd0, cfg_mode}, 8'd2);
    acc(3'd2, 8'h00, 1'b1, 1'b1);
    chk("R11 old efr read", bus_rdata, 8'h10);
    chk("R11 new efr", efr_q, 8'h00);
    @(negedge clk);
    chk("R11 rdata hold", bus_rdata, 8'h10);

    // R2 reset in mid run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R2 lcr after reset", lcr_q, 8'h00);
    chk("R2 dll after reset", dll_q, 8'h00);
    chk("R2 tcr after reset", tcr_q, 8'h00);
    chk("R2 rdata after reset", bus_rdata, 8'h00);
    chk("R2 mode after reset", {6'd0, cfg_mode}, 8'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule